// File: doc/BRIEF.md
# Byte-Lane Delay Register Interface with CPU Halt

This block is a bus slave on a 16-bit microprocessor bus. Behind it sit two 8-bit register devices, one on each byte lane. Each device holds three output port registers and one control (mode) register. Both devices share a single chip select. The lower and upper data strobes decide which device a write or read cycle reaches. The two address bits choose the register inside the device.

The port registers drive two buses. The first is an 8-bit DAC code bus. The second is a 24-bit digital delay bus. Both carry the bitwise inverse of what was written, so a written value of zero programs the longest delay.

The remaining two port registers come out as a 16-bit auxiliary output. A separate halt output silences the processor. It rises on a trigger event and falls when a sample-taken event arrives.

Top module: `bytelane_delay_regs`

## Requirements
- R1: After reset every port register and mode register is zero and halt is low. So `dac_o` = 8'hFF, `delay_o` = 24'hFFFFFF, `aux_o` = 16'h0000 and a control read returns 8'h00.
- R2: A write takes effect only in the clock cycle where `bus_wr` is high after having been low on the previous clock, with `bus_cs` high in that cycle. Holding `bus_wr` high writes once only, and a strobe pulse with `bus_cs` low changes nothing.
- R3: `bus_lds` routes a cycle to the lower device using data bits 7:0. `bus_uds` routes it to the upper device using data bits 15:8. With both strobes active, the same-addressed register in both devices is written.
- R4: `bus_addr` selects the register inside a device: 0 is port A, 1 is port B, 2 is port C and 3 is the control register.
- R5: `dac_o` equals the bitwise inverse of the lower device's port A.
- R6: `delay_o` equals the bitwise inverse of {upper port B, upper port A, lower port B}, with upper port B in bits 23:16. Writing zero to all three gives 24'hFFFFFF.
- R7: `aux_o` equals {upper port C, lower port C}, with upper port C in bits 15:8, and is not inverted.
- R8: While `bus_cs` and `bus_rd` are high, each lane whose strobe is active returns the addressed register of its device; port addresses return the last written value and address 3 returns the stored mode byte. A lane whose strobe is inactive reads 0, and `bus_rdata` is 0 when no read is in progress.
- R9: A control write whose bit 7 is clear leaves the mode byte unchanged. A control write with bit 7 set stores the whole byte. No control write changes any port register or output.
- R10: `halt_o` rises the clock after `trig_i` and falls the clock after `sample_i`. When both arrive in the same cycle, `sample_i` wins. A trigger while halt is already high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Shared chip select for both devices |
| bus_lds | input | 1 | Lower byte strobe (lower device) |
| bus_uds | input | 1 | Upper byte strobe (upper device) |
| bus_wr | input | 1 | Write strobe, acts on its rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register select inside a device |
| bus_wdata | input | 16 | Write data, one byte per lane |
| bus_rdata | output | 16 | Read data, one byte per lane |
| trig_i | input | 1 | Trigger event, sets halt |
| sample_i | input | 1 | Sample-taken event, clears halt |
| halt_o | output | 1 | CPU halt request |
| dac_o | output | 8 | Inverted DAC code bus |
| delay_o | output | 24 | Inverted digital delay bus |
| aux_o | output | 16 | Port C registers of both devices |

## Verification
The bench holds the write strobe high across several clocks with changing data. A design that wrote at level instead of at the edge would take the later data. Cycles with the chip select low and one-strobe cycles target the lane gating. A leaky design would update the idle device or read back a non-zero byte on the idle lane. Control writes with bit 7 clear and set are issued between port checks. This catches a design that stores every control byte or lets the mode write spill into a port. The halt tests repeat a trigger while halted and send trigger and sample together. A wrong priority shows up as halt staying high.

// File: rtl/bytelane_delay_pkg.sv
package bytelane_delay_pkg;
    localparam int BYTE_W   = 8;
    localparam int NPORT    = 3;
    localparam int ADDR_W   = 2;
    localparam int LANES    = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/lane_port_dev.sv
module lane_port_dev
    import bytelane_delay_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int NP = NPORT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [W-1:0]           wdata,
    output logic [NP-1:0][W-1:0]   ports_o,
    output logic [W-1:0]           rdata_o
);
    localparam int MODE_EN = W - 1;

    typedef struct packed {
        logic [NP-1:0][W-1:0] ports;
        logic [W-1:0]         mode;
    } dev_state_t;

    dev_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == SEL_CTRL) begin
                if (wdata[MODE_EN]) st_d.mode = wdata;
            end else if (int'(addr) < NP) begin
                st_d.ports[addr] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            if (addr == SEL_CTRL)         rdata_o = st_q.mode;
            else if (int'(addr) < NP)     rdata_o = st_q.ports[addr];
        end
    end

    assign ports_o = st_q.ports;

    // R9: a control write never touches a port register
    assert_ctrl_no_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_CTRL) |=> $stable(ports_o));

    // R9: mode byte keeps its value when bit 7 of the write is clear
    assert_mode_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_CTRL && !wdata[MODE_EN]) |=> $stable(st_q.mode));

    // R2: no enable, no change
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ports_o) && $stable(st_q.mode)));

    for (genvar p = 0; p < NP; p++) begin : g_port_chk
        // R4: a port write lands in the addressed register
        assert_port_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(addr) == p) |=> ports_o[p] == $past(wdata));
    end
endmodule

// File: rtl/halt_ctl.sv
module halt_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic sample_i,
    output logic halt_o
);
    logic halt_d, halt_q;

    always_comb begin
        halt_d = halt_q;
        if (sample_i)    halt_d = 1'b0;
        else if (trig_i) halt_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= halt_d;
    end

    assign halt_o = halt_q;

    // R10: halt only rises after a trigger without a sample
    assert_halt_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> ($past(trig_i) && !$past(sample_i)));

    // R10: halt only falls after a sample
    assert_halt_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_o) |-> $past(sample_i));

    // R10: a sample always leaves halt low
    assert_sample_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> !halt_o);
endmodule

// File: rtl/bytelane_delay_regs.sv
module bytelane_delay_regs
    import bytelane_delay_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int NP = NPORT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cs,
    input  logic                bus_lds,
    input  logic                bus_uds,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [LANES*W-1:0]  bus_wdata,
    output logic [LANES*W-1:0]  bus_rdata,
    input  logic                trig_i,
    input  logic                sample_i,
    output logic                halt_o,
    output logic [W-1:0]        dac_o,
    output logic [3*W-1:0]      delay_o,
    output logic [LANES*W-1:0]  aux_o
);
    logic wr_d, wr_q;
    logic wr_edge;
    logic [LANES-1:0] lane_strb;
    logic [LANES-1:0][NP-1:0][W-1:0] port_q;

    always_comb wr_d = bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= wr_d;
    end

    assign wr_edge   = bus_wr && !wr_q && bus_cs;
    assign lane_strb = {bus_uds, bus_lds};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_port_dev #(.W(W), .NP(NP)) u_dev (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_edge && lane_strb[l]),
            .rd_en   (bus_cs && bus_rd && lane_strb[l]),
            .addr    (bus_addr),
            .wdata   (bus_wdata[l*W +: W]),
            .ports_o (port_q[l]),
            .rdata_o (bus_rdata[l*W +: W])
        );
    end

    halt_ctl u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .sample_i (sample_i),
        .halt_o   (halt_o)
    );

    assign dac_o   = ~port_q[0][SEL_A];
    assign delay_o = ~{port_q[1][SEL_B], port_q[1][SEL_A], port_q[0][SEL_B]};
    assign aux_o   = {port_q[1][SEL_C], port_q[0][SEL_C]};

    // R2: a held write strobe writes only once
    assert_level_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(bus_wr)) |=> $stable(port_q));

    // R2: nothing is written without chip select
    assert_no_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs |=> $stable(port_q));

    // R3: the lower device ignores cycles without its strobe
    assert_lower_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_lds |=> $stable(port_q[0]));

    // R3: the upper device ignores cycles without its strobe
    assert_upper_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_uds |=> $stable(port_q[1]));

    // R8: idle bus returns zero
    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_rd) |-> bus_rdata == '0);
endmodule

// File: tb/bytelane_delay_regs_tb.sv
module bytelane_delay_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, lds = 1'b0, uds = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic trig = 1'b0, sample = 1'b0;
    logic [15:0] rdata;
    logic halt;
    logic [7:0] dac;
    logic [23:0] dly;
    logic [15:0] aux;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytelane_delay_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_lds(lds), .bus_uds(uds),
        .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .trig_i(trig), .sample_i(sample), .halt_o(halt),
        .dac_o(dac), .delay_o(dly), .aux_o(aux)
    );

    // behavioural reference: m_reg[lane][addr], entry 3 holds the mode byte
    logic [7:0] m_reg [2][4];
    logic m_wr_prev;
    logic m_halt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < 2; l++)
                for (int a = 0; a < 4; a++) m_reg[l][a] = 8'h00;
            m_wr_prev = 1'b0;
            m_halt = 1'b0;
        end else begin
            if (wr && !m_wr_prev && cs) begin
                for (int l = 0; l < 2; l++) begin
                    if ((l == 0 && lds) || (l == 1 && uds)) begin
                        if (addr != 2'd3) m_reg[l][addr] = wdata[l*8 +: 8];
                        else if (wdata[l*8+7]) m_reg[l][3] = wdata[l*8 +: 8];
                    end
                end
            end
            m_wr_prev = wr;
            if (sample) m_halt = 1'b0;
            else if (trig) m_halt = 1'b1;
        end
    end

    function automatic logic [15:0] exp_rdata();
        logic [15:0] v = 16'h0;
        if (cs && rd) begin
            if (lds) v[7:0]  = m_reg[0][addr];
            if (uds) v[15:8] = m_reg[1][addr];
        end
        return v;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n) begin
            check({24'h0, dac}, {24'h0, ~m_reg[0][0]}, "R5 dac bus");
            check({8'h0, dly}, {8'h0, ~{m_reg[1][1], m_reg[1][0], m_reg[0][1]}}, "R6 delay bus");
            check({16'h0, aux}, {16'h0, m_reg[1][2], m_reg[0][2]}, "R7 aux bus");
            check({31'h0, halt}, {31'h0, m_halt}, "R10 halt");
            check({16'h0, rdata}, {16'h0, exp_rdata()}, "R8 read data");
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d,
                             input logic l, input logic u, input logic c);
        @(negedge clk);
        cs = c; lds = l; uds = u; addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; cs = 1'b0; lds = 1'b0; uds = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic l, input logic u,
                            input logic [15:0] exp, input string tag);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; lds = l; uds = u; addr = a;
        #1;
        check({16'h0, rdata}, {16'h0, exp}, tag);
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; lds = 1'b0; uds = 1'b0;
    endtask

    task automatic pulse(input logic t, input logic s);
        @(negedge clk);
        trig = t; sample = s;
        @(negedge clk);
        trig = 1'b0; sample = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check({24'h0, dac}, 32'hFF, "R1 dac after reset");
        check({8'h0, dly}, 32'hFFFFFF, "R1 delay after reset");
        check({16'h0, aux}, 32'h0, "R1 aux after reset");
        check({31'h0, halt}, 32'h0, "R1 halt after reset");
        bus_read(2'd3, 1'b1, 1'b1, 16'h0000, "R1 mode after reset");

        // R3 R4 R5 lower lane port A
        bus_write(2'd0, 16'hC35A, 1'b1, 1'b0, 1'b1);
        check({24'h0, dac}, 32'hA5, "R5 dac inverted lower A");
        bus_read(2'd0, 1'b1, 1'b1, 16'h005A, "R3 upper lane untouched");

        // R2 held strobe: data changes while wr stays high
        @(negedge clk);
        cs = 1'b1; lds = 1'b1; addr = 2'd0; wdata = 16'h0011; wr = 1'b1;
        @(negedge clk);
        wdata = 16'h0022;
        @(negedge clk);
        wdata = 16'h0033;
        @(negedge clk);
        wr = 1'b0; cs = 1'b0; lds = 1'b0;
        #1;
        check({24'h0, dac}, 32'hEE, "R2 single write on held strobe");

        // R2 no chip select
        bus_write(2'd0, 16'h00F0, 1'b1, 1'b0, 1'b0);
        check({24'h0, dac}, 32'hEE, "R2 write without cs ignored");

        // R3 both strobes, R6
        bus_write(2'd1, 16'h1234, 1'b1, 1'b1, 1'b1);
        bus_write(2'd0, 16'h5600, 1'b0, 1'b1, 1'b1);
        check({24'h0, dac}, 32'hEE, "R3 upper-only write spares lower A");
        check({8'h0, dly}, 32'hEDA9CB, "R6 delay composition");

        // R7 port C via both lanes
        bus_write(2'd2, 16'hBEEF, 1'b1, 1'b1, 1'b1);
        check({16'h0, aux}, 32'hBEEF, "R7 aux ports C");
        bus_read(2'd2, 1'b0, 1'b1, 16'hBE00, "R8 upper-only read");

        // R9 control register
        bus_write(2'd3, 16'h0505, 1'b1, 1'b1, 1'b1);
        bus_read(2'd3, 1'b1, 1'b1, 16'h0000, "R9 mode write with bit7 clear ignored");
        bus_write(2'd3, 16'h9B8B, 1'b1, 1'b1, 1'b1);
        bus_read(2'd3, 1'b1, 1'b1, 16'h9B8B, "R9 mode write with bit7 set stored");
        check({16'h0, aux}, 32'hBEEF, "R9 ports unchanged by mode write");
        check({8'h0, dly}, 32'hEDA9CB, "R9 delay unchanged by mode write");

        // R6 zero word gives maximum delay
        bus_write(2'd1, 16'h0000, 1'b1, 1'b1, 1'b1);
        bus_write(2'd0, 16'h0000, 1'b0, 1'b1, 1'b1);
        check({8'h0, dly}, 32'hFFFFFF, "R6 zero word maximum delay");

        // R10 halt window
        pulse(1'b1, 1'b0);
        check({31'h0, halt}, 32'h1, "R10 trigger sets halt");
        pulse(1'b1, 1'b0);
        check({31'h0, halt}, 32'h1, "R10 trigger while halted");
        pulse(1'b0, 1'b1);
        check({31'h0, halt}, 32'h0, "R10 sample clears halt");
        pulse(1'b1, 1'b1);
        check({31'h0, halt}, 32'h0, "R10 sample wins over trigger");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule